// File: doc/BRIEF.md
# Edge-Pulse PWM Reconstruction Receiver

This block sits on the isolated side of a gate-drive path and rebuilds a PWM gate command that crosses the barrier only as short edge pulses. One input line carries a brief pulse for every turn-on edge of the command. The other line carries a brief pulse for every turn-off edge. Both lines are already sliced to clean synchronous digital levels by a comparator ahead of this block.

Each line passes through its own width qualifier. A pulse counts only after it has stayed high for a minimum number of clock cycles. Shorter activity is dropped as noise. A qualified turn-on pulse sets the held gate level and a qualified turn-off pulse clears it. The level is then held with no time limit until the next qualified pulse. This lets the transformer carry any duty cycle without ever resting in one polarity.

The block drives a complementary pair of gate commands to the output stage. It also drives two one-clock strobes that mark the start and the end of each gate cycle for the protection and fault logic downstream.

Top module: `edge_pwm_rx`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), gate_cmd is 0, gate_cmd_n is 1, and cycle_start and cycle_end are both 0.
- R2: When on_pulse has been high for MIN_WIDTH consecutive clock edges and gate_cmd is 0, gate_cmd becomes 1 at the MIN_WIDTH-th of those edges.
- R3: When off_pulse has been high for MIN_WIDTH consecutive clock edges and gate_cmd is 1, gate_cmd becomes 0 at the MIN_WIDTH-th of those edges.
- R4: A pulse on either input that stays high for fewer than MIN_WIDTH consecutive edges changes neither gate_cmd nor either strobe.
- R5: gate_cmd_n is always the inverse of gate_cmd.
- R6: While both inputs are low, gate_cmd keeps its value for any number of cycles.
- R7: If both inputs reach their qualifying edge in the same cycle, the result is gate_cmd = 0. A cycle_end strobe is produced only if gate_cmd was 1.
- R8: cycle_start is high for exactly one cycle on each 0-to-1 change of gate_cmd, and cycle_end is high for exactly one cycle on each 1-to-0 change. They are registered together with gate_cmd, and they are never high at the same time.
- R9: A qualified turn-on pulse while gate_cmd is 1, or a qualified turn-off pulse while gate_cmd is 0, leaves gate_cmd unchanged and produces no strobe.
- R10: A pulse that stays high longer than MIN_WIDTH qualifies only once. A turn-on line held high after gate_cmd has been cleared by the other line does not set gate_cmd again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_pulse | input | 1 | Sliced turn-on edge pulse line |
| off_pulse | input | 1 | Sliced turn-off edge pulse line |
| gate_cmd | output | 1 | Reconstructed gate command, 1 = ON |
| gate_cmd_n | output | 1 | Complement of gate_cmd |
| cycle_start | output | 1 | One-cycle strobe on an accepted ON transition |
| cycle_end | output | 1 | One-cycle strobe on an accepted OFF transition |

## Verification
Several properties are checked on every clock cycle:
- the complement pair always disagrees;
- each strobe matches a real change of the held level and lasts one cycle;
- the level stays put while both lines are idle;
- a simultaneous qualification on both lines ends in the OFF state.

The directed scenarios cover what needs a chosen stimulus:
- the exact edge on which a pulse of MIN_WIDTH cycles takes effect;
- the rejection of pulses one cycle too short;
- repeated pulses that must change nothing;
- a long hold between edges;
- a turn-on line that stays high across a turn-off, which must not qualify a second time.

// File: rtl/edge_rx_pkg.sv
// Package: shared lane indices and gate state type for the edge-pulse receiver.
// Assumes: lane 0 carries turn-on pulses, lane 1 carries turn-off pulses.
package edge_rx_pkg;
    localparam int LANES    = 2;
    localparam int LANE_ON  = 0;
    localparam int LANE_OFF = 1;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;
endpackage

// File: rtl/edge_rx_qualify.sv
// Module: edge_rx_qualify
// Checks one sliced pulse line against a minimum width. A saturating counter
// counts consecutive high samples. qual is high for exactly one cycle: the
// cycle in which the MIN_WIDTH-th consecutive high sample is present.
// Assumes: din is synchronous to clk and MIN_WIDTH >= 1.
module edge_rx_qualify #(
    parameter int MIN_WIDTH = 10,
    parameter int CNT_W     = $clog2(MIN_WIDTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic qual
);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_WIDTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_WIDTH - 1);

    logic [CNT_W-1:0] run_cnt;

    // Count consecutive high samples, clear on low, hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!din) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_SAT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Flag the single cycle in which the width requirement is met.
    always_comb begin
        qual = din && (run_cnt == CNT_LAST);
    end
endmodule

// File: rtl/edge_rx_state.sv
// Module: edge_rx_state
// Holds the reconstructed gate level and produces the cycle strobes.
// OFF wins when both qualify events coincide. Redundant events are ignored.
// Assumes: on_evt and off_evt are single-cycle qualify flags.
module edge_rx_state
    import edge_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_evt,
    input  logic off_evt,
    output logic gate_q,
    output logic gate_qn,
    output logic start_stb,
    output logic end_stb
);
    gate_state_e state_q;
    gate_state_e state_d;
    logic        go_on;
    logic        go_off;

    // Decide the next level: turn-off has priority, repeats do nothing.
    always_comb begin
        go_off  = off_evt && (state_q == GATE_ON);
        go_on   = on_evt && !off_evt && (state_q == GATE_OFF);
        state_d = state_q;
        if (off_evt) begin
            state_d = GATE_OFF;
        end else if (go_on) begin
            state_d = GATE_ON;
        end
    end

    // Register the level, its complement and the transition strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= GATE_OFF;
            gate_qn   <= 1'b1;
            start_stb <= 1'b0;
            end_stb   <= 1'b0;
        end else begin
            state_q   <= state_d;
            gate_qn   <= (state_d == GATE_OFF);
            start_stb <= go_on;
            end_stb   <= go_off;
        end
    end

    // Present the held state as a plain level.
    always_comb begin
        gate_q = (state_q == GATE_ON);
    end
endmodule

// File: rtl/edge_pwm_rx.sv
// Module: edge_pwm_rx (top)
// Rebuilds a PWM gate command from separate turn-on and turn-off edge pulse
// lines. Each line is width-qualified, then a state holder keeps the level.
// Assumes: both inputs are already sliced and synchronous to clk.
module edge_pwm_rx
    import edge_rx_pkg::*;
#(
    parameter int MIN_WIDTH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_pulse,
    input  logic off_pulse,
    output logic gate_cmd,
    output logic gate_cmd_n,
    output logic cycle_start,
    output logic cycle_end
);
    localparam int CNT_W = $clog2(MIN_WIDTH + 1);

    logic [LANES-1:0] lane_raw;
    logic [LANES-1:0] lane_qual;
    logic             pos_qual;
    logic             neg_qual;

    // Gather the two input lines into lane order.
    always_comb begin
        lane_raw[LANE_ON]  = on_pulse;
        lane_raw[LANE_OFF] = off_pulse;
    end

    // One width qualifier per input line.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edge_rx_qualify #(
            .MIN_WIDTH (MIN_WIDTH),
            .CNT_W     (CNT_W)
        ) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_raw[g]),
            .qual  (lane_qual[g])
        );
    end

    // Name the qualify events for the state holder and the checker.
    always_comb begin
        pos_qual = lane_qual[LANE_ON];
        neg_qual = lane_qual[LANE_OFF];
    end

    edge_rx_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_evt    (pos_qual),
        .off_evt   (neg_qual),
        .gate_q    (gate_cmd),
        .gate_qn   (gate_cmd_n),
        .start_stb (cycle_start),
        .end_stb   (cycle_end)
    );
endmodule

// File: rtl/edge_pwm_rx_chk.sv
// Module: edge_pwm_rx_chk
// Cycle-by-cycle properties of the receiver, bound into the top module.
module edge_pwm_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic on_pulse,
    input logic off_pulse,
    input logic pos_qual,
    input logic neg_qual,
    input logic gate_cmd,
    input logic gate_cmd_n,
    input logic cycle_start,
    input logic cycle_end
);
    // R5: complementary outputs always disagree
    p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd != gate_cmd_n);

    // R8: start strobe marks a real 0-to-1 change
    p_start_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (gate_cmd && !$past(gate_cmd)));

    // R8: end strobe marks a real 1-to-0 change
    p_end_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> (!gate_cmd && $past(gate_cmd)));

    // R8: strobes last one cycle
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);

    // R8: strobes never together
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cycle_start && cycle_end));

    // R6: idle inputs keep the level
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_pulse && !off_pulse) |=> $stable(gate_cmd));

    // R7: simultaneous qualification lands in OFF
    p_both_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_qual && neg_qual) |=> !gate_cmd);

    // R9: no start strobe while already ON
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd |=> !cycle_start);
endmodule

bind edge_pwm_rx edge_pwm_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_pulse    (on_pulse),
    .off_pulse   (off_pulse),
    .pos_qual    (pos_qual),
    .neg_qual    (neg_qual),
    .gate_cmd    (gate_cmd),
    .gate_cmd_n  (gate_cmd_n),
    .cycle_start (cycle_start),
    .cycle_end   (cycle_end)
);

// File: tb/edge_pwm_rx_bench.sv
// Directed bench for edge_pwm_rx. Inputs and samples change on the falling edge.
module edge_pwm_rx_bench;
    localparam int MW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_pulse = 1'b0;
    logic off_pulse = 1'b0;
    logic gate_cmd, gate_cmd_n, cycle_start, cycle_end;

    int vectors = 0;
    int errors = 0;
    int n_start = 0;
    int n_end = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_pwm_rx #(.MIN_WIDTH(MW)) u_edge_pwm_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .on_pulse    (on_pulse),
        .off_pulse   (off_pulse),
        .gate_cmd    (gate_cmd),
        .gate_cmd_n  (gate_cmd_n),
        .cycle_start (cycle_start),
        .cycle_end   (cycle_end)
    );

    // Tally strobe cycles away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cycle_start) n_start++;
            if (cycle_end) n_end++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_level(input string req, input int exp);
        check(req, int'(gate_cmd), exp);
        check("R5", int'(gate_cmd_n), 1 - exp);
    endtask

    // Drive the chosen lines high for len falling edges, then release them.
    task automatic send(input bit p, input bit n, input int len);
        on_pulse = p;
        off_pulse = n;
        repeat (len) @(negedge clk);
        on_pulse = 1'b0;
        off_pulse = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_level("R1", 0);
        check("R1", int'(cycle_start) + int'(cycle_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_level("R1", 0);
    endtask

    // Output must not change before the MIN_WIDTH-th edge, and must change on it.
    task automatic t_turn_on();
        int s0 = n_start;
        on_pulse = 1'b1;
        repeat (MW - 1) @(negedge clk);
        check("R2", int'(gate_cmd), 0);
        @(negedge clk);
        check_level("R2", 1);
        check("R8", int'(cycle_start), 1);
        on_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", n_start - s0, 1);
    endtask

    task automatic t_hold();
        repeat (600) @(negedge clk);
        check_level("R6", 1);
    endtask

    task automatic t_repeat_on();
        int s0 = n_start;
        send(1, 0, MW);
        check_level("R9", 1);
        check("R9", n_start - s0, 0);
    endtask

    task automatic t_short_off();
        int e0 = n_end;
        send(0, 1, MW - 1);
        check_level("R4", 1);
        check("R4", n_end - e0, 0);
    endtask

    task automatic t_turn_off();
        int e0 = n_end;
        off_pulse = 1'b1;
        repeat (MW - 1) @(negedge clk);
        check("R3", int'(gate_cmd), 1);
        @(negedge clk);
        check_level("R3", 0);
        check("R8", int'(cycle_end), 1);
        off_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", n_end - e0, 1);
    endtask

    task automatic t_repeat_off();
        int e0 = n_end;
        send(0, 1, MW);
        check_level("R9", 0);
        check("R9", n_end - e0, 0);
    endtask

    task automatic t_short_on();
        int s0 = n_start;
        send(1, 0, MW - 1);
        check_level("R4", 0);
        check("R4", n_start - s0, 0);
    endtask

    task automatic t_both();
        int s0 = n_start;
        int e0 = n_end;
        send(1, 1, MW);
        check_level("R7", 0);
        check("R7", n_start - s0 + n_end - e0, 0);
        send(1, 0, MW);
        check_level("R2", 1);
        e0 = n_end;
        s0 = n_start;
        send(1, 1, MW);
        check_level("R7", 0);
        check("R7", n_end - e0, 1);
        check("R7", n_start - s0, 0);
    endtask

    // Turn-on line held across a turn-off must not qualify again.
    task automatic t_long_on();
        int s0 = n_start;
        on_pulse = 1'b1;
        repeat (MW) @(negedge clk);
        check_level("R10", 1);
        off_pulse = 1'b1;
        repeat (MW) @(negedge clk);
        off_pulse = 1'b0;
        check_level("R10", 0);
        repeat (3 * MW) @(negedge clk);
        check_level("R10", 0);
        check("R10", n_start - s0, 1);
        on_pulse = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_turn_on();
        t_hold();
        t_repeat_on();
        t_short_off();
        t_turn_off();
        t_repeat_off();
        t_short_on();
        t_both();
        t_long_on();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule